// File: doc/BRIEF.md
# Operand Address Generator

This block turns an operand specifier of a two-operand processor into a 32-bit operand address. It receives a 3-bit mode, a 3-bit register number, the operand size, up to two 16-bit extension words, and the current contents of eight data registers and eight address registers. It returns the effective address in the same cycle. For the two register-direct modes it returns the register value itself.

For the two modes that modify their base register, the block also produces a write-back value and a register number. These are registered and arrive together with a one-cycle enable strobe, which the register file can consume directly. The block does not access memory, decode instructions or fetch extension words. It only does the arithmetic.

Mode codes: 000 data register, 001 address register, 010 indirect, 011 indirect with post-increment, 100 indirect with pre-decrement, 101 indirect plus 16-bit displacement, 110 indirect plus 8-bit displacement plus index, 111 absolute. In mode 111 the register field picks the form: 000 is short and 001 is long.

The indexed extension word is laid out as follows:

| Bits | Meaning |
|------|---------|
| 15 | Index register kind: 1 address, 0 data |
| 14:12 | Index register number |
| 11 | Index width: 1 full 32 bits, 0 sign-extended lower 16 bits |
| 10:9 | Left shift of the index: 00 ×1, 01 ×2, 10 ×4, 11 ×8 |
| 8 | Must be 0 |
| 7:0 | Signed displacement |

Top module: `ea_calc_unit`

## Requirements
- R1: Mode 000 gives `ea` equal to the data register chosen by `reg_num`. Mode 001 gives `ea` equal to the chosen address register. Neither mode raises `wb_en`.
- R2: Mode 010 gives `ea` equal to the chosen address register, unmodified.
- R3: Mode 011 gives `ea` equal to the address register. One clock later it presents `wb_value` = register + step and `wb_reg` = `reg_num`.
- R4: Mode 100 gives `ea` = register − step. One clock later it presents that same value on `wb_value` and the register number on `wb_reg`. The subtraction wraps modulo 2^32.
- R5: The step is 1 for byte size (`op_size` 00), 2 for word size (01), and 4 for long size (10) or the reserved code (11). A byte step on register 7 is 2.
- R6: Mode 101 gives `ea` = address register + sign-extended `ext_word0`.
- R7: Mode 110 gives `ea` = address register + sign-extended `ext_word0[7:0]` + scaled index. The index register is taken from `ext_word0[15:12]`, with bit 15 = 1 selecting an address register.
- R8: In mode 110, when `ext_word0[11]` is 0 the index is the sign extension of its lower 16 bits. The index is then shifted left by `ext_word0[10:9]` (×1, ×2, ×4, ×8).
- R9: Mode 111 with register field 000 gives `ea` = sign-extended `ext_word0`. With register field 001 it gives `ea` = {`ext_word0`, `ext_word1`}.
- R10: Mode 111 with a register field of 010 to 111, or mode 110 with `ext_word0[8]` = 1, raises `mode_err` and drives `ea` to 0.
- R11: `wb_en` is high for exactly the cycle after a rising edge at which `req_valid` was high with mode 011 or 100. It is low otherwise and low after a synchronous active-low reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Specifier on the inputs is a real request |
| mode | input | 3 | Addressing mode code |
| reg_num | input | 3 | Register field |
| op_size | input | 2 | Operand size code |
| ext_word0 | input | 16 | First extension word |
| ext_word1 | input | 16 | Second extension word (low half of absolute long) |
| data_regs | input | 256 | Data registers, register i at bits [32i+31:32i] |
| addr_regs | input | 256 | Address registers, register i at bits [32i+31:32i] |
| ea | output | 32 | Effective address or register value |
| mode_err | output | 1 | Specifier is not a legal combination |
| wb_en | output | 1 | Registered write-back strobe |
| wb_reg | output | 3 | Address register to write back |
| wb_value | output | 32 | Updated address register value |

## Verification
`ea` and `mode_err` follow the inputs in the same cycle. `wb_en`, `wb_reg` and `wb_value` are due one rising edge after the request. The bench drives each specifier on a falling edge and records the expected results in a queue. The monitor compares both groups of results 1 ns after the following rising edge. At that point the inputs have not yet moved and the registered write-back already reflects the same request, so one sample point serves both latencies.

// File: rtl/ea_pkg.sv
// Package of shared encodings for the operand address generator.
// Assumes a 3-bit mode field and a 2-bit operand size field.
package ea_pkg;

    typedef enum logic [2:0] {
        AM_DREG    = 3'd0,
        AM_AREG    = 3'd1,
        AM_IND     = 3'd2,
        AM_POSTINC = 3'd3,
        AM_PREDEC  = 3'd4,
        AM_DISP    = 3'd5,
        AM_INDEX   = 3'd6,
        AM_EXT     = 3'd7
    } amode_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_RSVD = 2'd3
    } opsize_e;

    // Register-field codes of the absolute mode
    localparam logic [2:0] EXT_ABS_SHORT = 3'd0;
    localparam logic [2:0] EXT_ABS_LONG  = 3'd1;

endpackage

// File: rtl/ea_reg_pick.sv
// Selects one register out of a flattened register bank.
// Assumes register i sits at bits [i*AW +: AW] and that sel < NREG.
module ea_reg_pick #(
    parameter int AW   = 32,
    parameter int NREG = 8,
    localparam int RW  = $clog2(NREG)
) (
    input  logic [NREG*AW-1:0] regs_flat,
    input  logic [RW-1:0]      sel,
    output logic [AW-1:0]      val
);

    // Indexed part-select of the requested register
    always_comb begin
        val = regs_flat[sel*AW +: AW];
    end

endmodule

// File: rtl/ea_step_gen.sv
// Produces the byte step used by post-increment and pre-decrement.
// Assumes the highest-numbered register is the stack pointer, which must
// stay word aligned, so a byte step on it is widened to 2.
module ea_step_gen #(
    parameter int AW   = 32,
    parameter int NREG = 8,
    localparam int RW  = $clog2(NREG)
) (
    input  ea_pkg::opsize_e op_size,
    input  logic [RW-1:0]   reg_num,
    output logic [AW-1:0]   step
);

    localparam logic [RW-1:0] SP_NUM = RW'(NREG - 1);

    // Map the operand size (and the stack pointer case) to a byte count
    always_comb begin
        unique case (op_size)
            ea_pkg::SZ_BYTE: step = (reg_num == SP_NUM) ? AW'(2) : AW'(1);
            ea_pkg::SZ_WORD: step = AW'(2);
            default:         step = AW'(4);
        endcase
    end

endmodule

// File: rtl/ea_index_unit.sv
// Forms the scaled index term of the indexed mode.
// Assumes the index is either used whole or narrowed to its sign-extended
// lower 16 bits, then shifted left by 0 to 3 positions.
module ea_index_unit #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] idx_raw,
    input  logic          idx_full,
    input  logic [1:0]    idx_shift,
    output logic [AW-1:0] idx_scaled
);

    logic [AW-1:0] idx_sized;

    // Choose full width or the sign-extended lower half-word
    always_comb begin
        if (idx_full) idx_sized = idx_raw;
        else          idx_sized = AW'($signed(idx_raw[15:0]));
    end

    // Apply the scale factor 1, 2, 4 or 8
    always_comb begin
        idx_scaled = idx_sized << idx_shift;
    end

endmodule

// File: rtl/ea_calc_unit.sv
// Operand address generator: computes the effective address of one operand
// specifier combinationally and registers the base-register update of the
// auto-modifying modes. Assumes register banks are flattened, register i at
// [i*AW +: AW]; the write-back strobe lasts one cycle per request.
module ea_calc_unit #(
    parameter int AW   = 32,
    parameter int NREG = 8,
    parameter int EXTW = 16,
    localparam int RW  = $clog2(NREG)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [2:0]           mode,
    input  logic [RW-1:0]        reg_num,
    input  logic [1:0]           op_size,
    input  logic [EXTW-1:0]      ext_word0,
    input  logic [EXTW-1:0]      ext_word1,
    input  logic [NREG*AW-1:0]   data_regs,
    input  logic [NREG*AW-1:0]   addr_regs,
    output logic [AW-1:0]        ea,
    output logic                 mode_err,
    output logic                 wb_en,
    output logic [RW-1:0]        wb_reg,
    output logic [AW-1:0]        wb_value
);
    import ea_pkg::*;

    amode_e        am;
    opsize_e       sz;
    logic [AW-1:0] base_an;
    logic [AW-1:0] direct_dn;
    logic [AW-1:0] idx_from_d;
    logic [AW-1:0] idx_from_a;
    logic [AW-1:0] idx_raw;
    logic [AW-1:0] idx_scaled;
    logic [AW-1:0] step;
    logic [AW-1:0] an_dec;
    logic [AW-1:0] an_inc;
    logic          auto_mod;

    // Cast the raw code fields to their enumerations
    always_comb begin
        am = amode_e'(mode);
        sz = opsize_e'(op_size);
    end

    ea_reg_pick #(.AW(AW), .NREG(NREG)) u_pick_base (
        .regs_flat (addr_regs),
        .sel       (reg_num),
        .val       (base_an)
    );

    ea_reg_pick #(.AW(AW), .NREG(NREG)) u_pick_dn (
        .regs_flat (data_regs),
        .sel       (reg_num),
        .val       (direct_dn)
    );

    ea_reg_pick #(.AW(AW), .NREG(NREG)) u_pick_idx_d (
        .regs_flat (data_regs),
        .sel       (ext_word0[12 +: RW]),
        .val       (idx_from_d)
    );

    ea_reg_pick #(.AW(AW), .NREG(NREG)) u_pick_idx_a (
        .regs_flat (addr_regs),
        .sel       (ext_word0[12 +: RW]),
        .val       (idx_from_a)
    );

    // Index register kind is chosen by the top bit of the extension word
    always_comb begin
        idx_raw = ext_word0[15] ? idx_from_a : idx_from_d;
    end

    ea_index_unit #(.AW(AW)) u_index (
        .idx_raw    (idx_raw),
        .idx_full   (ext_word0[11]),
        .idx_shift  (ext_word0[10:9]),
        .idx_scaled (idx_scaled)
    );

    ea_step_gen #(.AW(AW), .NREG(NREG)) u_step (
        .op_size (sz),
        .reg_num (reg_num),
        .step    (step)
    );

    // Candidate updated base values for the two auto-modifying modes
    always_comb begin
        an_inc = base_an + step;
        an_dec = base_an - step;
    end

    // Effective address and legality per mode
    always_comb begin
        ea       = '0;
        mode_err = 1'b0;
        unique case (am)
            AM_DREG:    ea = direct_dn;
            AM_AREG:    ea = base_an;
            AM_IND:     ea = base_an;
            AM_POSTINC: ea = base_an;
            AM_PREDEC:  ea = an_dec;
            AM_DISP:    ea = base_an + AW'($signed(ext_word0));
            AM_INDEX: begin
                if (ext_word0[8]) mode_err = 1'b1;
                else ea = base_an + AW'($signed(ext_word0[7:0])) + idx_scaled;
            end
            AM_EXT: begin
                if (reg_num == RW'(EXT_ABS_SHORT))
                    ea = AW'($signed(ext_word0));
                else if (reg_num == RW'(EXT_ABS_LONG))
                    ea = AW'({ext_word0, ext_word1});
                else
                    mode_err = 1'b1;
            end
            default:    ea = '0;
        endcase
    end

    // A request that must update its base register
    always_comb begin
        auto_mod = req_valid && ((am == AM_POSTINC) || (am == AM_PREDEC));
    end

    // Registered write-back strobe, target and value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_en    <= 1'b0;
            wb_reg   <= '0;
            wb_value <= '0;
        end else begin
            wb_en <= auto_mod;
            if (auto_mod) begin
                wb_reg   <= reg_num;
                wb_value <= (am == AM_POSTINC) ? an_inc : an_dec;
            end
        end
    end

endmodule

// File: rtl/ea_calc_checker.sv
// Property checker for the operand address generator, attached by bind.
// Assumes the same parameters as the unit it watches.
module ea_calc_checker #(
    parameter int AW   = 32,
    parameter int NREG = 8,
    parameter int EXTW = 16,
    localparam int RW  = $clog2(NREG)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic [2:0]         mode,
    input logic [RW-1:0]      reg_num,
    input logic [EXTW-1:0]    ext_word0,
    input logic [EXTW-1:0]    ext_word1,
    input logic [NREG*AW-1:0] addr_regs,
    input logic [AW-1:0]      ea,
    input logic               mode_err,
    input logic               wb_en,
    input logic [RW-1:0]      wb_reg,
    input logic [AW-1:0]      wb_value
);

    a_r11_strobe_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (mode == 3'd3 || mode == 3'd4)) |=> wb_en);

    a_r11_no_spurious_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && (mode == 3'd3 || mode == 3'd4)) |=> !wb_en);

    a_r4_predec_writes_ea: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && mode == 3'd4) |=> (wb_value == $past(ea) && wb_reg == $past(reg_num)));

    a_r3_postinc_step: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && mode == 3'd3) |=>
            ((wb_value - $past(ea)) == AW'(1) || (wb_value - $past(ea)) == AW'(2) ||
             (wb_value - $past(ea)) == AW'(4)));

    a_r2_indirect_plain: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd2) |-> (ea == addr_regs[reg_num*AW +: AW]));

    a_r9_abs_long: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd7 && reg_num == RW'(1)) |-> (ea == AW'({ext_word0, ext_word1}) && !mode_err));

    a_r10_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
        mode_err |-> (ea == '0 && (mode == 3'd7 || mode == 3'd6)));

endmodule

bind ea_calc_unit ea_calc_checker #(.AW(AW), .NREG(NREG), .EXTW(EXTW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .mode      (mode),
    .reg_num   (reg_num),
    .ext_word0 (ext_word0),
    .ext_word1 (ext_word1),
    .addr_regs (addr_regs),
    .ea        (ea),
    .mode_err  (mode_err),
    .wb_en     (wb_en),
    .wb_reg    (wb_reg),
    .wb_value  (wb_value)
);

// File: tb/tb_ea_calc_unit.sv
// Scoreboard bench: the driver computes expected results and queues them,
// the monitor pops one per cycle after the rising edge and compares.
module tb_ea_calc_unit;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic [2:0]   mode = '0;
    logic [2:0]   reg_num = '0;
    logic [1:0]   op_size = '0;
    logic [15:0]  ext_word0 = '0;
    logic [15:0]  ext_word1 = '0;
    logic [255:0] data_regs;
    logic [255:0] addr_regs;
    logic [31:0]  ea;
    logic         mode_err;
    logic         wb_en;
    logic [2:0]   wb_reg;
    logic [31:0]  wb_value;

    logic [31:0] dr [8];
    logic [31:0] ar [8];

    typedef struct {
        string       tag;
        logic [31:0] ea;
        logic        err;
        logic        wbe;
        logic [2:0]  wbr;
        logic [31:0] wbv;
    } exp_t;

    exp_t q[$];
    int   n_vec = 0;
    int   n_bad = 0;
    bit   done = 0;

    always #5 clk = ~clk;

    ea_calc_unit dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mode(mode),
        .reg_num(reg_num), .op_size(op_size), .ext_word0(ext_word0),
        .ext_word1(ext_word1), .data_regs(data_regs), .addr_regs(addr_regs),
        .ea(ea), .mode_err(mode_err), .wb_en(wb_en), .wb_reg(wb_reg),
        .wb_value(wb_value)
    );

    always_comb begin
        for (int i = 0; i < 8; i++) begin
            data_regs[i*32 +: 32] = dr[i];
            addr_regs[i*32 +: 32] = ar[i];
        end
    end

    // Drive one specifier on a falling edge and queue its expected results
    task automatic apply(input string tag, input logic v, input logic [2:0] m,
                         input logic [2:0] r, input logic [1:0] s,
                         input logic [15:0] e0, input logic [15:0] e1);
        exp_t        x;
        logic [31:0] an, stp, ix;
        @(negedge clk);
        req_valid = v; mode = m; reg_num = r; op_size = s;
        ext_word0 = e0; ext_word1 = e1;
        an  = ar[r];
        stp = (s == 2'd0) ? ((r == 3'd7) ? 32'd2 : 32'd1) : (s == 2'd1) ? 32'd2 : 32'd4;
        x.tag = tag; x.err = 1'b0; x.ea = 32'd0;
        x.wbe = v && (m == 3'd3 || m == 3'd4); x.wbr = r; x.wbv = 32'd0;
        case (m)
            3'd0: x.ea = dr[r];
            3'd1, 3'd2, 3'd3: x.ea = an;
            3'd4: x.ea = an - stp;
            3'd5: x.ea = an + {{16{e0[15]}}, e0};
            3'd6: begin
                ix = e0[15] ? ar[e0[14:12]] : dr[e0[14:12]];
                if (!e0[11]) ix = {{16{ix[15]}}, ix[15:0]};
                ix = ix * (32'd1 << e0[10:9]);
                if (e0[8]) x.err = 1'b1;
                else x.ea = an + {{24{e0[7]}}, e0[7:0]} + ix;
            end
            default: begin
                if (r == 3'd0) x.ea = {{16{e0[15]}}, e0};
                else if (r == 3'd1) x.ea = {e0, e1};
                else x.err = 1'b1;
            end
        endcase
        if (m == 3'd3) x.wbv = an + stp;
        if (m == 3'd4) x.wbv = an - stp;
        q.push_back(x);
    endtask

    // Monitor: compare after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t x;
                bit   bad;
                x = q.pop_front();
                n_vec++;
                bad = (ea !== x.ea) || (mode_err !== x.err) || (wb_en !== x.wbe);
                if (x.wbe) bad = bad || (wb_value !== x.wbv) || (wb_reg !== x.wbr);
                if (bad) begin
                    n_bad++;
                    $display("FAIL %s: ea=%h err=%b wbe=%b wbr=%0d wbv=%h expected ea=%h err=%b wbe=%b wbr=%0d wbv=%h",
                             x.tag, ea, mode_err, wb_en, wb_reg, wb_value,
                             x.ea, x.err, x.wbe, x.wbr, x.wbv);
                end
            end
        end
    end

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    // Watchdog
    initial begin
        #2000000;
        n_bad++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 8; i++) begin
            dr[i] = 32'h0001_8000 + i * 32'h1111_0010;
            ar[i] = 32'h8000_0000 + i * 32'h0010_0004;
        end
        ar[0] = 32'h0000_0000;
        // Reset state with a post-increment request held during reset (R11)
        @(negedge clk);
        req_valid = 1'b1; mode = 3'd3; reg_num = 3'd2;
        @(posedge clk); @(posedge clk); #1;
        n_vec++;
        if (wb_en !== 1'b0) begin
            n_bad++;
            $display("FAIL R11 reset: wb_en=%b expected 0", wb_en);
        end
        @(negedge clk);
        req_valid = 1'b0;
        rst_n = 1'b1;

        apply("R1 data direct",   1, 3'd0, 3'd3, 2'd2, 16'h0, 16'h0);
        apply("R1 addr direct",   1, 3'd1, 3'd5, 2'd2, 16'h0, 16'h0);
        apply("R2 indirect",      1, 3'd2, 3'd4, 2'd1, 16'h0, 16'h0);
        apply("R3 postinc long",  1, 3'd3, 3'd2, 2'd2, 16'h0, 16'h0);
        apply("R3 postinc word",  1, 3'd3, 3'd0, 2'd1, 16'h0, 16'h0);
        apply("R4 predec long",   1, 3'd4, 3'd1, 2'd2, 16'h0, 16'h0);
        apply("R4 predec wrap",   1, 3'd4, 3'd0, 2'd2, 16'h0, 16'h0);
        apply("R5 byte step",     1, 3'd3, 3'd3, 2'd0, 16'h0, 16'h0);
        apply("R5 byte on sp inc",1, 3'd3, 3'd7, 2'd0, 16'h0, 16'h0);
        apply("R5 byte on sp dec",1, 3'd4, 3'd7, 2'd0, 16'h0, 16'h0);
        apply("R5 byte dec",      1, 3'd4, 3'd6, 2'd0, 16'h0, 16'h0);
        apply("R5 word dec",      1, 3'd4, 3'd6, 2'd1, 16'h0, 16'h0);
        apply("R5 reserved size", 1, 3'd4, 3'd5, 2'd3, 16'h0, 16'h0);
        apply("R6 disp positive", 1, 3'd5, 3'd1, 2'd2, 16'h7FFF, 16'h0);
        apply("R6 disp negative", 1, 3'd5, 3'd3, 2'd2, 16'h8000, 16'h0);
        apply("R7 index data",    1, 3'd6, 3'd2, 2'd2, 16'h3880, 16'h0);
        apply("R7 index addr",    1, 3'd6, 3'd6, 2'd2, 16'hD805, 16'h0);
        apply("R8 short x8",      1, 3'd6, 3'd1, 2'd2, 16'h0610, 16'h0);
        apply("R8 long x4",       1, 3'd6, 3'd1, 2'd2, 16'h0C10, 16'h0);
        apply("R8 short x2 addr", 1, 3'd6, 3'd4, 2'd2, 16'hB2FF, 16'h0);
        apply("R9 abs short neg", 1, 3'd7, 3'd0, 2'd2, 16'h8000, 16'h0);
        apply("R9 abs short pos", 1, 3'd7, 3'd0, 2'd2, 16'h1234, 16'h0);
        apply("R9 abs long",      1, 3'd7, 3'd1, 2'd2, 16'hDEAD, 16'hBEEF);
        apply("R10 bad abs form", 1, 3'd7, 3'd3, 2'd2, 16'h1111, 16'h2222);
        apply("R10 bad index ext",1, 3'd6, 3'd2, 2'd2, 16'h0100, 16'h0);
        apply("R11 idle postinc", 0, 3'd3, 3'd2, 2'd2, 16'h0, 16'h0);
        apply("R11 back to back", 1, 3'd4, 3'd3, 2'd1, 16'h0, 16'h0);
        apply("R11 back to back", 1, 3'd3, 3'd5, 2'd0, 16'h0, 16'h0);
        apply("R11 non-auto",     1, 3'd5, 3'd5, 2'd0, 16'h0004, 16'h0);
        repeat (3) @(posedge clk);
        #2;
        finish_run();
    end

endmodule